// File: doc/BRIEF.md
# Host-to-Flat-Bus Address Translator

This block sits between a processor request port and a single-beat system bus. Each host request carries an access kind: memory, I/O port or model-specific register. The block folds all three kinds into one flat 32-bit map.

- Memory addresses keep their value. They are steered to one of three regions: system RAM, PCI space or on-chip peripherals.
- I/O port numbers are moved into a fixed 64 KB window of that map.
- Model-specific register cycles never reach the bus. Writes are dropped and reads return a constant.
- An access that has no legal place in the map gets an error response without any bus traffic.

Exactly one transaction is in flight at a time. The host sees ready only while the block is idle. The bus request is registered and held until the slave accepts it. The host then receives a single-cycle response carrying read data and an error flag.

Top module: `xaddr_xlate`

## Requirements
- R1: Out of reset, hreq_ready_o is 1, bus_valid_o is 0 and hrsp_valid_o is 0.
- R2: A memory access (kind 0) below 8000_0000h is issued on the bus at the unchanged address with region code 0 (RAM).
- R3: A memory access in 8000_0000h..BFFF_FFFFh is issued at the unchanged address with region code 1 (PCI).
- R4: A memory access at C001_0000h or above is issued at the unchanged address with region code 3 (peripheral).
- R5: An I/O access (kind 1) to port P, where address bits 31:16 are zero, is issued at C000_0000h + P with region code 2 (I/O window).
- R6: A memory access inside C000_0000h..C000_FFFFh gets a response one cycle after acceptance, with hrsp_err_o=1 and data 0, and no bus request is made.
- R7: An I/O access with any of address bits 31:16 set, or any access of kind 3, is rejected in the same way as in R6.
- R8: An MSR write (kind 2) makes no bus request and gets a response one cycle after acceptance, with error 0 and data 0.
- R9: An MSR read makes no bus request and gets a response one cycle after acceptance, with error 0 and data equal to the MSR_RDATA parameter.
- R10: bus_valid_o rises one cycle after acceptance. Address, region, write flag and write data stay stable until the cycle in which bus_ready_i is high, and that cycle completes the transfer.
- R11: The host response comes one cycle after the bus transfer completes, with error 0. Its data is bus_rdata_i as sampled at completion for reads, and 0 for writes.
- R12: hrsp_valid_o lasts exactly one cycle. hreq_ready_o is low from acceptance until the cycle after the response, so only one transaction is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hreq_valid_i | input | 1 | Host request present |
| hreq_ready_o | output | 1 | Block can accept a host request |
| hreq_kind_i | input | 2 | 0 memory, 1 I/O, 2 MSR, 3 reserved |
| hreq_write_i | input | 1 | 1 for write |
| hreq_addr_i | input | 32 | Host address or port number |
| hreq_wdata_i | input | 32 | Host write data |
| hrsp_valid_o | output | 1 | One-cycle response strobe |
| hrsp_rdata_o | output | 32 | Response read data |
| hrsp_err_o | output | 1 | Decode error |
| bus_valid_o | output | 1 | Bus request valid |
| bus_ready_i | input | 1 | Bus completes the transfer in this cycle |
| bus_addr_o | output | 32 | Flat bus address |
| bus_region_o | output | 2 | 0 RAM, 1 PCI, 2 I/O window, 3 peripheral |
| bus_write_o | output | 1 | Bus write |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data, sampled at completion |

## Verification
Some internal faults show up on the bus side in the cycle right after acceptance: a wrong decode gives a wrong region code or remapped address, and a misrouted local cycle raises bus_valid_o when it should stay low. A controller stuck in its bus state keeps hreq_ready_o low and never strobes a response. A lost capture register returns the wrong data on the response strobe, one cycle after completion. The bench therefore compares every transaction's bus fields, response timing and response data against a reference model of the map. It runs the region boundaries and varied slave wait times alongside random traffic.

// File: rtl/xat_pkg.sv
package xat_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {KIND_MEM, KIND_IO, KIND_MSR, KIND_RSVD} kind_e;
  typedef enum logic [1:0] {RG_RAM, RG_PCI, RG_IO, RG_PERIPH} region_e;
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_RSP} state_e;

  typedef struct packed {
    logic              local_done;
    logic              err;
    region_e           region;
    logic [ADDR_W-1:0] addr;
  } route_t;
endpackage

// File: rtl/xat_decode.sv
module xat_decode
  import xat_pkg::*;
#(
  parameter logic [31:0] RAM_TOP   = 32'h8000_0000,
  parameter logic [31:0] PCI_TOP   = 32'hC000_0000,
  parameter logic [31:0] IO_BASE   = 32'hC000_0000,
  parameter int          IO_SPAN_W = 16
) (
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output route_t            route_o
);
  localparam logic [ADDR_W:0] IO_TOP = {1'b0, IO_BASE} + ({{ADDR_W{1'b0}}, 1'b1} << IO_SPAN_W);

  logic [ADDR_W-1:0] port_ext;
  assign port_ext = {{(ADDR_W-IO_SPAN_W){1'b0}}, addr_i[IO_SPAN_W-1:0]};

  always_comb begin
    route_o = '0;
    route_o.addr = addr_i;
    unique case (kind_i)
      KIND_MEM: begin
        if (addr_i < RAM_TOP)             route_o.region = RG_RAM;
        else if (addr_i < PCI_TOP)        route_o.region = RG_PCI;
        else if (addr_i >= IO_BASE && {1'b0, addr_i} < IO_TOP)
                                          route_o.err = 1'b1;  // no memory alias onto ports
        else                              route_o.region = RG_PERIPH;
      end
      KIND_IO: begin
        route_o.region = RG_IO;
        route_o.addr   = IO_BASE + port_ext;
        route_o.err    = |addr_i[ADDR_W-1:IO_SPAN_W];
      end
      KIND_MSR: route_o.local_done = 1'b1;
      default:  route_o.err = 1'b1;
    endcase
  end
endmodule

// File: rtl/xat_ctrl.sv
module xat_ctrl
  import xat_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] MSR_RDATA = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_fire_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  route_t            route_i,
  output logic              idle_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output region_e           bus_region_o,
  output logic              bus_write_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  state_e            st_q;
  logic [ADDR_W-1:0] addr_q;
  region_e           region_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      region_q <= RG_RAM;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_fire_i) begin
          write_q <= req_write_i;
          if (route_i.err) begin
            err_q   <= 1'b1;
            rdata_q <= '0;
            st_q    <= ST_RSP;
          end else if (route_i.local_done) begin
            err_q   <= 1'b0;
            rdata_q <= req_write_i ? '0 : MSR_RDATA;
            st_q    <= ST_RSP;
          end else begin
            addr_q   <= route_i.addr;
            region_q <= route_i.region;
            wdata_q  <= req_wdata_i;
            st_q     <= ST_BUS;
          end
        end
        ST_BUS: if (bus_ready_i) begin
          err_q   <= 1'b0;
          rdata_q <= write_q ? '0 : bus_rdata_i;
          st_q    <= ST_RSP;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o       = (st_q == ST_IDLE);
  assign bus_valid_o  = (st_q == ST_BUS);
  assign rsp_valid_o  = (st_q == ST_RSP);
  assign rsp_rdata_o  = rdata_q;
  assign rsp_err_o    = err_q;
  assign bus_addr_o   = addr_q;
  assign bus_region_o = region_q;
  assign bus_write_o  = write_q;
  assign bus_wdata_o  = wdata_q;
endmodule

// File: rtl/xaddr_xlate.sv
module xaddr_xlate
  import xat_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] MSR_RDATA = '0,
  parameter int                IO_SPAN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hreq_valid_i,
  output logic              hreq_ready_o,
  input  logic [1:0]        hreq_kind_i,
  input  logic              hreq_write_i,
  input  logic [ADDR_W-1:0] hreq_addr_i,
  input  logic [DATA_W-1:0] hreq_wdata_i,
  output logic              hrsp_valid_o,
  output logic [DATA_W-1:0] hrsp_rdata_o,
  output logic              hrsp_err_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_region_o,
  output logic              bus_write_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  route_t  route;
  region_e region;

  xat_decode #(.IO_SPAN_W(IO_SPAN_W)) u_dec (
    .kind_i  (kind_e'(hreq_kind_i)),
    .addr_i  (hreq_addr_i),
    .route_o (route)
  );

  xat_ctrl #(.DATA_W(DATA_W), .MSR_RDATA(MSR_RDATA)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_fire_i   (hreq_valid_i & hreq_ready_o),
    .req_write_i  (hreq_write_i),
    .req_wdata_i  (hreq_wdata_i),
    .route_i      (route),
    .idle_o       (hreq_ready_o),
    .rsp_valid_o  (hrsp_valid_o),
    .rsp_rdata_o  (hrsp_rdata_o),
    .rsp_err_o    (hrsp_err_o),
    .bus_valid_o  (bus_valid_o),
    .bus_ready_i  (bus_ready_i),
    .bus_addr_o   (bus_addr_o),
    .bus_region_o (region),
    .bus_write_o  (bus_write_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_rdata_i  (bus_rdata_i)
  );

  assign bus_region_o = region;
endmodule

// File: rtl/xaddr_xlate_chk.sv
module xaddr_xlate_chk #(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] MSR_RDATA = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hreq_valid_i,
  input logic              hreq_ready_o,
  input logic [1:0]        hreq_kind_i,
  input logic              hreq_write_i,
  input logic [31:0]       hreq_addr_i,
  input logic              hrsp_valid_o,
  input logic [DATA_W-1:0] hrsp_rdata_o,
  input logic              hrsp_err_o,
  input logic              bus_valid_o,
  input logic              bus_ready_i,
  input logic [31:0]       bus_addr_o,
  input logic [1:0]        bus_region_o
);
  logic fire;
  assign fire = hreq_valid_i && hreq_ready_o;

  // R10
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_addr_o) && $stable(bus_region_o));

  // R12
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o || hrsp_valid_o) |-> !hreq_ready_o);

  // R12
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrsp_valid_o |=> !hrsp_valid_o && hreq_ready_o);

  // R11
  bus_done_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i |=> hrsp_valid_o && !hrsp_err_o);

  // R5
  io_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_region_o == 2'd2 |-> bus_addr_o[31:16] == 16'hC000);

  // R2
  ram_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_region_o == 2'd0 |-> !bus_addr_o[31]);

  // R6
  mem_io_alias_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && hreq_kind_i == 2'd0 && hreq_addr_i[31:16] == 16'hC000
      |=> hrsp_valid_o && hrsp_err_o && !bus_valid_o);

  // R9
  msr_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && hreq_kind_i == 2'd2 && !hreq_write_i
      |=> hrsp_valid_o && !hrsp_err_o && !bus_valid_o && hrsp_rdata_o == MSR_RDATA);
endmodule

bind xaddr_xlate xaddr_xlate_chk #(.DATA_W(DATA_W), .MSR_RDATA(MSR_RDATA)) u_chk (.*);

// File: tb/sim_xaddr_xlate.sv
module sim_xaddr_xlate;
  localparam logic [31:0] MSR_VAL = 32'hFEED_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hreq_valid = 1'b0;
  logic        hreq_ready;
  logic [1:0]  hreq_kind = '0;
  logic        hreq_write = 1'b0;
  logic [31:0] hreq_addr = '0;
  logic [31:0] hreq_wdata = '0;
  logic        hrsp_valid;
  logic [31:0] hrsp_rdata;
  logic        hrsp_err;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic [1:0]  bus_region;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xaddr_xlate #(.MSR_RDATA(MSR_VAL)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .hreq_valid_i(hreq_valid), .hreq_ready_o(hreq_ready), .hreq_kind_i(hreq_kind),
    .hreq_write_i(hreq_write), .hreq_addr_i(hreq_addr), .hreq_wdata_i(hreq_wdata),
    .hrsp_valid_o(hrsp_valid), .hrsp_rdata_o(hrsp_rdata), .hrsp_err_o(hrsp_err),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready), .bus_addr_o(bus_addr),
    .bus_region_o(bus_region), .bus_write_o(bus_write), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // reference map: returns 1 when a bus request is expected
  function automatic bit model(input logic [1:0] k, input logic [31:0] a, output logic [31:0] ea,
                               output logic [1:0] er, output bit eerr, output string req);
    ea = a; er = 2'd0; eerr = 1'b0; req = "R8";
    case (k)
      2'd0: begin
        if (!a[31])                    begin er = 2'd0; req = "R2"; return 1; end
        else if (a[31:30] == 2'b10)    begin er = 2'd1; req = "R3"; return 1; end
        else if (a[31:16] == 16'hC000) begin eerr = 1; req = "R6"; return 0; end
        else                           begin er = 2'd3; req = "R4"; return 1; end
      end
      2'd1: begin
        if (a[31:16] != 0) begin eerr = 1; req = "R7"; return 0; end
        ea = 32'hC000_0000 + {16'h0, a[15:0]}; er = 2'd2; req = "R5"; return 1;
      end
      2'd2: begin req = "R9"; return 0; end
      default: begin eerr = 1; req = "R7"; return 0; end
    endcase
  endfunction

  task automatic run(input logic [1:0] k, input bit wr, input logic [31:0] a,
                     input logic [31:0] wd, input logic [31:0] brd, input int dly);
    logic [31:0] ea, exp_data, s_addr, s_wd, r_data;
    logic [1:0]  er, s_reg;
    bit eerr, want_bus, seen_bus, got, r_err, s_wr, moved;
    string req;
    int waited, rsp_at;
    want_bus = model(k, a, ea, er, eerr, req);
    if (k == 2'd2 && wr) req = "R8";
    chk(hreq_ready == 1'b1, "R12", {31'd0, hreq_ready}, 32'd1);
    hreq_valid = 1'b1; hreq_kind = k; hreq_write = wr; hreq_addr = a; hreq_wdata = wd;
    bus_rdata = brd;
    @(negedge clk);
    hreq_valid = 1'b0; hreq_addr = $urandom; hreq_wdata = $urandom;
    seen_bus = 0; got = 0; moved = 0; waited = 0; rsp_at = -1;
    s_addr = '0; s_reg = '0; s_wr = 0; s_wd = '0; r_data = '0; r_err = 0;
    for (int c = 0; c < 40 && !got; c++) begin
      bus_ready = 1'b0;
      if (bus_valid) begin
        if (!seen_bus) begin
          seen_bus = 1; s_addr = bus_addr; s_reg = bus_region; s_wr = bus_write; s_wd = bus_wdata;
        end else if (bus_addr != s_addr || bus_region != s_reg || bus_write != s_wr || bus_wdata != s_wd)
          moved = 1;
        if (waited >= dly) bus_ready = 1'b1;
        waited++;
      end
      if (hrsp_valid) begin
        got = 1; rsp_at = c; r_data = hrsp_rdata; r_err = hrsp_err;
      end
      if (!got) @(negedge clk);
    end
    bus_ready = 1'b0;
    chk(got, req, 32'd0, 32'd1);
    chk(seen_bus == want_bus, req, {31'd0, seen_bus}, {31'd0, want_bus});
    if (want_bus) begin
      chk(s_addr == ea, req, s_addr, ea);
      chk(s_reg == er, req, {30'd0, s_reg}, {30'd0, er});
      chk(s_wr == wr && (!wr || s_wd == wd), "R10", s_wd, wd);
      chk(!moved, "R10", s_addr, ea);
      chk(rsp_at == dly + 1, "R11", rsp_at, dly + 1);
      exp_data = wr ? 32'd0 : brd;
      chk(r_data == exp_data && !r_err, "R11", r_data, exp_data);
    end else begin
      chk(rsp_at == 0, req, rsp_at, 0);
      exp_data = (k == 2'd2 && !wr) ? MSR_VAL : 32'd0;
      chk(r_err == eerr, req, {31'd0, r_err}, {31'd0, eerr});
      chk(r_data == exp_data, req, r_data, exp_data);
    end
    @(negedge clk);
    chk(!hrsp_valid && hreq_ready, "R12", {30'd0, hrsp_valid, hreq_ready}, 32'd1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R1
    chk(hreq_ready && !bus_valid && !hrsp_valid, "R1", {29'd0, hreq_ready, bus_valid, hrsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hreq_ready && !bus_valid && !hrsp_valid, "R1", {29'd0, hreq_ready, bus_valid, hrsp_valid}, 32'd4);
    // directed corners
    run(2'd0, 0, 32'h7FFF_FFFC, 0, 32'h1111_2222, 0);      // R2
    run(2'd0, 1, 32'h0000_0000, 32'hABCD_0123, 0, 2);     // R2 write
    run(2'd0, 0, 32'h8000_0000, 0, 32'h3333_4444, 1);      // R3
    run(2'd0, 0, 32'hBFFF_FFFC, 0, 32'h5555_6666, 0);      // R3
    run(2'd0, 0, 32'hC000_0000, 0, 0, 0);                  // R6
    run(2'd0, 1, 32'hC000_FFFC, 32'h1, 0, 0);              // R6
    run(2'd0, 0, 32'hC001_0000, 0, 32'h7777_8888, 3);      // R4
    run(2'd0, 1, 32'hFFFF_FFFC, 32'h99, 0, 5);             // R4
    run(2'd1, 0, 32'h0000_0000, 0, 32'h0000_00AA, 0);      // R5
    run(2'd1, 1, 32'h0000_FFFF, 32'h55, 0, 1);             // R5
    run(2'd1, 0, 32'h0001_0000, 0, 0, 0);                  // R7
    run(2'd3, 0, 32'h0000_1000, 0, 0, 0);                  // R7
    run(2'd2, 0, 32'h0000_0010, 0, 32'hDEAD_BEEF, 0);      // R9
    run(2'd2, 1, 32'h0000_0010, 32'hFFFF_FFFF, 0, 0);      // R8
    run(2'd0, 0, 32'h1234_5678, 0, 32'hCAFE_F00D, 9);      // R10 long wait
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  k;
      logic [31:0] a;
      k = 2'($urandom % 4);
      case ($urandom % 6)
        0: a = $urandom & 32'h7FFF_FFFF;
        1: a = 32'h8000_0000 | ($urandom & 32'h3FFF_FFFF);
        2: a = 32'hC000_0000 | ($urandom & 32'h0000_FFFF);
        3: a = 32'hC001_0000 + ($urandom % 32'h3FFE_FFFF);
        4: a = $urandom & 32'h0000_FFFF;
        default: a = $urandom;
      endcase
      run(k, 1'($urandom), a, $urandom, $urandom, int'($urandom % 5));
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule